// File: doc/BRIEF.md
# Indexed Address Generator

This block turns a one-byte indexed-mode selector into a 16-bit effective address for a small 8/16-bit processor core. The selector names a base pointer (X, Y, SP or PC) and a way to offset it. The offset can be a short constant held in the selector itself, a one- or two-byte constant that follows in the instruction stream, or accumulator A, B or D. Auto-increment and auto-decrement forms also update the base pointer, before or after it is used. Two forms are memory-indirect: the block reads a 16-bit pointer from memory, and that pointer becomes the address.

The core pulses `start` with the selector and a restricted-mode flag. Extension bytes come in through a request/acknowledge byte port. Indirect pointers are read one byte at a time through a second request/acknowledge port. When the address is ready, `done` pulses for one cycle. In that same cycle the block shows any pointer write-back, flags whether the form costs one extra bus cycle, and flags whether the form was rejected.

Top module: `idx_agu`

## Requirements
- R1: When selector bit 5 is 0, bits 7:6 pick the base (0=X, 1=Y, 2=SP, 3=PC) and bits 4:0 are a two's-complement offset from -16 to +15 added to it.
- R2: When bit 5 is 1 and bits 7:6 are not 11, the form is auto-update. Bits 3:0 with bit 3 set give a negative step from -8 to -1. Otherwise the step is the field value plus one (1 to 8). During `done`, `wb_en` is 1, `wb_sel` names the base (0=X, 1=Y, 2=SP) and `wb_data` is base plus step. No other form raises `wb_en`.
- R3: In auto-update, bit 4 = 0 makes the address the updated pointer (pre-modify), and bit 4 = 1 makes it the original pointer (post-modify).
- R4: When bits 7:6 are 11 (base in bits 4:3) and bit 2 is 0, a constant offset is fetched. Bit 1 = 1 fetches two bytes, high byte first. Bit 1 = 0 fetches one byte, whose upper byte is all ones when bit 0 is 1 and zero otherwise.
- R5: When bits 7:6 are 11, bit 2 is 1 and bits 1:0 are 00, 01 or 10, the offset is A (zero-extended), B (zero-extended) or D = {A,B}.
- R6: Bits 7:6 = 11 with bits 2:0 = 011 fetch a two-byte offset and use base plus offset as a pointer. Bits 2:0 = 111 use base plus D as a pointer. The pointer is read as a byte at the pointer and then a byte at the pointer plus one. The first byte is the high half of the address.
- R7: When PC is the base, the value used is `reg_pc` plus the number of extension bytes the form fetches.
- R8: With `restrict_mode` set at start, the 9-bit and 16-bit constant forms and both indirect forms fetch no byte and read no memory. They finish with address 0 and `illegal` = 1. The other forms behave exactly as without restriction.
- R9: During `done`, `extra_cycle` is 1 for the constant-offset forms and the indirect forms, and 0 for all other forms and for rejected forms.
- R10: After reset, `done`, `ext_req`, `mem_req`, `wb_en` and `illegal` are 0. `done` is high for exactly one cycle. For a form with no fetch and no read, `done` rises on the second clock edge after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding; sampled while idle |
| postbyte | input | 8 | Indexed-mode selector byte |
| restrict_mode | input | 1 | Reject extended and indirect forms |
| reg_x | input | 16 | X pointer value |
| reg_y | input | 16 | Y pointer value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter after the selector byte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| ext_req | output | 1 | Extension byte wanted |
| ext_ack | input | 1 | Extension byte present |
| ext_byte | input | 8 | Extension byte value |
| mem_req | output | 1 | Pointer byte read wanted |
| mem_addr | output | 16 | Pointer byte address |
| mem_ack | input | 1 | Read data present |
| mem_rdata | input | 8 | Read byte |
| done | output | 1 | Effective address valid, one cycle |
| ea | output | 16 | Effective address |
| illegal | output | 1 | Form rejected in restricted mode (with done) |
| extra_cycle | output | 1 | Form costs one extra bus cycle (with done) |
| wb_en | output | 1 | Pointer write-back strobe (with done) |
| wb_sel | output | 2 | Pointer to write: 0=X, 1=Y, 2=SP |
| wb_data | output | 16 | Updated pointer value |

## Verification
In the `done` cycle of an auto-update form, the block gives the effective address and the pointer write-back together. In post-modify forms the two values differ. The bench runs pre- and post-modify selectors with positive and negative steps. In that single cycle it compares `ea` against the original or the stepped pointer, and `wb_data` against the stepped pointer. This shows that neither value was taken from the other's path. Restricted runs of the same auto-update selectors confirm that the write-back survives restriction, while the extended and indirect forms are rejected with no fetch traffic.

// File: rtl/idx_agu_pkg.sv
package idx_agu_pkg;

    localparam int AW = 16;           // address and pointer width
    localparam int BW = 8;            // byte width
    localparam int SHORT_W = 5;       // in-selector constant width
    localparam int STEP_W = 4;        // auto-update step field width

    typedef enum logic [2:0] {
        FAM_SHORT,
        FAM_AUTO,
        FAM_CONST,
        FAM_ACC,
        FAM_IND16,
        FAM_INDD
    } fam_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_ADDR,
        ST_RDH,
        ST_RDL,
        ST_DONE
    } st_e;

    typedef struct packed {
        fam_e          fam;
        logic [1:0]    base_sel;
        logic [AW-1:0] imm;       // short offset or auto step
        logic          post;
        logic [1:0]    n_ext;     // extension bytes to fetch
        logic          neg8;      // sign of a one-byte offset
        logic [1:0]    acc_sel;
        logic          gated;     // rejected in restricted mode
    } idx_dec_t;

    function automatic idx_dec_t decode_sel(input logic [BW-1:0] pb);
        idx_dec_t d;
        d = '0;
        if (!pb[5]) begin
            d.fam      = FAM_SHORT;
            d.base_sel = pb[7:6];
            d.imm      = {{(AW-SHORT_W){pb[4]}}, pb[SHORT_W-1:0]};
        end else if (pb[7:6] != 2'b11) begin
            d.fam      = FAM_AUTO;
            d.base_sel = pb[7:6];
            d.post     = pb[4];
            d.imm      = pb[3] ? {{(AW-STEP_W){1'b1}}, pb[STEP_W-1:0]}
                               : {{(AW-STEP_W){1'b0}}, pb[STEP_W-1:0]} + AW'(1);
        end else begin
            d.base_sel = pb[4:3];
            d.acc_sel  = pb[1:0];
            if (pb[2:0] == 3'b011) begin
                d.fam   = FAM_IND16;
                d.n_ext = 2'd2;
                d.gated = 1'b1;
            end else if (!pb[2]) begin
                d.fam   = FAM_CONST;
                d.n_ext = pb[1] ? 2'd2 : 2'd1;
                d.neg8  = pb[0];
                d.gated = 1'b1;
            end else if (pb[1:0] == 2'b11) begin
                d.fam   = FAM_INDD;
                d.gated = 1'b1;
            end else begin
                d.fam   = FAM_ACC;
            end
        end
        return d;
    endfunction

    function automatic logic costs_extra(input idx_dec_t d);
        return (d.n_ext != 2'd0) || (d.fam == FAM_INDD);
    endfunction

endpackage

// File: rtl/idx_decode.sv
module idx_decode
    import idx_agu_pkg::*;
(
    input  logic [BW-1:0] sel_byte,
    output idx_dec_t      dec
);
    always_comb dec = decode_sel(sel_byte);
endmodule

// File: rtl/idx_base_mux.sv
module idx_base_mux
    import idx_agu_pkg::*;
(
    input  logic [1:0]    base_sel,
    input  logic [1:0]    n_ext,
    input  logic [AW-1:0] reg_x,
    input  logic [AW-1:0] reg_y,
    input  logic [AW-1:0] reg_sp,
    input  logic [AW-1:0] reg_pc,
    output logic [AW-1:0] base
);
    logic [AW-1:0] pc_adj;

    // PC-relative forms see the counter past every extension byte
    assign pc_adj = reg_pc + {{(AW-2){1'b0}}, n_ext};

    always_comb begin
        unique case (base_sel)
            2'd0:    base = reg_x;
            2'd1:    base = reg_y;
            2'd2:    base = reg_sp;
            default: base = pc_adj;
        endcase
    end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
    import idx_agu_pkg::*;
(
    input  idx_dec_t      dec,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ext_off,
    input  logic [BW-1:0] acc_a,
    input  logic [BW-1:0] acc_b,
    output logic [AW-1:0] sum,
    output logic [AW-1:0] upd
);
    logic [AW-1:0] acc_off;

    assign upd = base + dec.imm;

    always_comb begin
        unique case (dec.acc_sel)
            2'd0:    acc_off = {{(AW-BW){1'b0}}, acc_a};
            2'd1:    acc_off = {{(AW-BW){1'b0}}, acc_b};
            default: acc_off = {acc_a, acc_b};
        endcase
    end

    always_comb begin
        unique case (dec.fam)
            FAM_SHORT:            sum = upd;
            FAM_AUTO:             sum = dec.post ? base : upd;
            FAM_CONST, FAM_IND16: sum = base + ext_off;
            default:              sum = base + acc_off;
        endcase
    end
endmodule

// File: rtl/idx_agu.sv
module idx_agu
    import idx_agu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    postbyte,
    input  logic          restrict_mode,
    input  logic [15:0]   reg_x,
    input  logic [15:0]   reg_y,
    input  logic [15:0]   reg_sp,
    input  logic [15:0]   reg_pc,
    input  logic [7:0]    acc_a,
    input  logic [7:0]    acc_b,
    output logic          ext_req,
    input  logic          ext_ack,
    input  logic [7:0]    ext_byte,
    output logic          mem_req,
    output logic [15:0]   mem_addr,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          done,
    output logic [15:0]   ea,
    output logic          illegal,
    output logic          extra_cycle,
    output logic          wb_en,
    output logic [1:0]    wb_sel,
    output logic [15:0]   wb_data
);
    st_e           st;
    idx_dec_t      dec_in, dec_q;
    logic [AW-1:0] base_in, base_q, off_q, ptr_q, ea_q, sum, upd;
    logic [BW-1:0] a_q, b_q;
    logic [1:0]    cnt_q;
    logic          ill_q, xtr_q;
    logic          rejected;
    logic          is_ind;

    idx_decode u_dec (
        .sel_byte (postbyte),
        .dec      (dec_in)
    );

    idx_base_mux u_base (
        .base_sel (dec_in.base_sel),
        .n_ext    (dec_in.n_ext),
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_sp   (reg_sp),
        .reg_pc   (reg_pc),
        .base     (base_in)
    );

    idx_ea_calc u_calc (
        .dec     (dec_q),
        .base    (base_q),
        .ext_off (off_q),
        .acc_a   (a_q),
        .acc_b   (b_q),
        .sum     (sum),
        .upd     (upd)
    );

    assign rejected = restrict_mode && dec_in.gated;
    assign is_ind   = (dec_q.fam == FAM_IND16) || (dec_q.fam == FAM_INDD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            dec_q  <= '0;
            base_q <= '0;
            off_q  <= '0;
            ptr_q  <= '0;
            ea_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            cnt_q  <= '0;
            ill_q  <= 1'b0;
            xtr_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    dec_q  <= dec_in;
                    base_q <= base_in;
                    a_q    <= acc_a;
                    b_q    <= acc_b;
                    off_q  <= '0;
                    cnt_q  <= dec_in.n_ext;
                    ill_q  <= rejected;
                    xtr_q  <= costs_extra(dec_in) && !rejected;
                    if (rejected) begin
                        ea_q <= '0;
                        st   <= ST_DONE;
                    end else if (dec_in.n_ext != 2'd0) begin
                        st   <= ST_EXT;
                    end else begin
                        st   <= ST_ADDR;
                    end
                end
                ST_EXT: if (ext_ack) begin
                    cnt_q <= cnt_q - 2'd1;
                    off_q <= (dec_q.n_ext == 2'd1)
                           ? {{(AW-BW){dec_q.neg8}}, ext_byte}
                           : {off_q[AW-BW-1:0], ext_byte};
                    if (cnt_q == 2'd1) st <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (is_ind) begin
                        ptr_q <= sum;
                        st    <= ST_RDH;
                    end else begin
                        ea_q  <= sum;
                        st    <= ST_DONE;
                    end
                end
                ST_RDH: if (mem_ack) begin
                    ea_q[AW-1:BW] <= mem_rdata;
                    st            <= ST_RDL;
                end
                ST_RDL: if (mem_ack) begin
                    ea_q[BW-1:0] <= mem_rdata;
                    st           <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done        = (st == ST_DONE);
    assign ext_req     = (st == ST_EXT);
    assign mem_req     = (st == ST_RDH) || (st == ST_RDL);
    assign mem_addr    = ptr_q + {{(AW-1){1'b0}}, (st == ST_RDL)};
    assign ea          = ea_q;
    assign illegal     = done && ill_q;
    assign extra_cycle = done && xtr_q;
    assign wb_en       = done && !ill_q && (dec_q.fam == FAM_AUTO);
    assign wb_sel      = dec_q.base_sel;
    assign wb_data     = upd;

endmodule

// File: rtl/idx_agu_chk.sv
module idx_agu_chk (
    input logic        clk,
    input logic        rst,
    input logic        ext_req,
    input logic        ext_ack,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic [15:0] ea,
    input logic        illegal,
    input logic        extra_cycle,
    input logic        wb_en
);
    p_wb_only_done_r2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    p_ext_held_r4: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_ack) |=> ext_req);

    p_rd_held_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_rd_next_byte_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + 16'd1));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(ext_req && mem_req));

    p_reject_zero_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && ea == 16'd0 && !wb_en && !extra_cycle));

    p_extra_done_r9: assert property (@(posedge clk) disable iff (rst)
        extra_cycle |-> done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind idx_agu idx_agu_chk u_chk (.*);

// File: tb/sim_idx_agu.sv
`timescale 1ns/100ps
module sim_idx_agu;

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  pb;
        logic        rs;
        logic [7:0]  e0;
        logic [7:0]  e1;
        logic [1:0]  nex;
        logic [1:0]  nrd;
        logic [15:0] ea;
        logic        wb;
        logic [1:0]  wsel;
        logic [15:0] wdat;
        logic        ill;
        logic        xtr;
    } vec_t;

    localparam int NV = 25;
    // Registers: X=1000 Y=2000 SP=3000 PC=4000 A=85 B=12 (D=8512)
    // Memory byte at address a: (a[7:0]^A5)+a[15:8]
    localparam vec_t TBL [NV] = '{
        '{4'd1, 8'h05, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1005, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R1 X+5
        '{4'd1, 8'h5F, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1FFF, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R1 Y-1
        '{4'd7, 8'hD0, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h3FF0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R7 PC-16
        '{4'd1, 8'h8F, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h300F, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R1 SP+15
        '{4'd3, 8'h22, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1003, 1'b1, 2'd0, 16'h1003, 1'b0, 1'b0}, // R3 pre +3
        '{4'd3, 8'h7F, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h2000, 1'b1, 2'd1, 16'h1FFF, 1'b0, 1'b0}, // R3 post -1
        '{4'd2, 8'hA8, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h2FF8, 1'b1, 2'd2, 16'h2FF8, 1'b0, 1'b0}, // R2 pre -8
        '{4'd2, 8'h37, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1000, 1'b1, 2'd0, 16'h1008, 1'b0, 1'b0}, // R2 post +8
        '{4'd4, 8'hE0, 1'b0, 8'h80, 8'h00, 2'd1, 2'd0, 16'h1080, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R4 9-bit +
        '{4'd4, 8'hE9, 1'b0, 8'h10, 8'h00, 2'd1, 2'd0, 16'h1F10, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R4 9-bit -
        '{4'd4, 8'hF2, 1'b0, 8'h12, 8'h34, 2'd2, 2'd0, 16'h4234, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R4 16-bit
        '{4'd7, 8'hFA, 1'b0, 8'h00, 8'h10, 2'd2, 2'd0, 16'h4012, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R7 PC 16-bit
        '{4'd7, 8'hF8, 1'b0, 8'h05, 8'h00, 2'd1, 2'd0, 16'h4006, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R7 PC 9-bit
        '{4'd5, 8'hE4, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1085, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R5 X+A
        '{4'd5, 8'hED, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h2012, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R5 Y+B
        '{4'd5, 8'hF6, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'hB512, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R5 SP+D
        '{4'd6, 8'hE3, 1'b0, 8'h01, 8'h00, 2'd2, 2'd2, 16'hB6B5, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R6 [X+0100]
        '{4'd6, 8'hEF, 1'b0, 8'h00, 8'h00, 2'd0, 2'd2, 16'h5C5B, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1}, // R6 [Y+D]
        '{4'd8, 8'hE3, 1'b1, 8'h01, 8'h00, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0}, // R8 reject
        '{4'd8, 8'hF2, 1'b1, 8'h12, 8'h34, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0}, // R8 reject
        '{4'd8, 8'hE0, 1'b1, 8'h80, 8'h00, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0}, // R8 reject
        '{4'd8, 8'hEF, 1'b1, 8'h00, 8'h00, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0}, // R8 reject
        '{4'd8, 8'h05, 1'b1, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1005, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R8 allowed
        '{4'd8, 8'h22, 1'b1, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1003, 1'b1, 2'd0, 16'h1003, 1'b0, 1'b0}, // R8 allowed
        '{4'd8, 8'hE4, 1'b1, 8'h00, 8'h00, 2'd0, 2'd0, 16'h1085, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}  // R8 allowed
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic        restrict_mode = 1'b0;
    logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3000, reg_pc = 16'h4000;
    logic [7:0]  acc_a = 8'h85, acc_b = 8'h12;
    logic        ext_ack = 1'b0;
    logic [7:0]  ext_byte = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        ext_req, mem_req, done, illegal, extra_cycle, wb_en;
    logic [15:0] mem_addr, ea, wb_data;
    logic [1:0]  wb_sel;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    idx_agu u0 (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] ^ 8'hA5) + a[15:8];
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int rd_wait);
        int nex = 0;
        int nrd = 0;
        int wcnt = 0;
        int cyc = 0;
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        postbyte = v.pb;
        restrict_mode = v.rs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 40) begin
            ext_ack = 1'b0;
            mem_ack = 1'b0;
            if (ext_req) begin
                ext_ack = 1'b1;
                ext_byte = (nex == 0) ? v.e0 : v.e1;
                nex++;
            end
            if (mem_req) begin
                if (wcnt >= rd_wait) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_byte(mem_addr);
                    nrd++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        ext_ack = 1'b0;
        mem_ack = 1'b0;
        chk(done == 1'b1, tag, $sformatf("done pb=%0h", v.pb), done, 1);
        chk(ea == v.ea, tag, $sformatf("ea pb=%0h", v.pb), ea, v.ea);
        chk(nex == int'(v.nex), tag, $sformatf("ext bytes pb=%0h", v.pb), nex, v.nex);
        chk(nrd == int'(v.nrd), tag, $sformatf("reads pb=%0h", v.pb), nrd, v.nrd);
        chk(illegal == v.ill, tag, $sformatf("illegal pb=%0h", v.pb), illegal, v.ill);
        chk(extra_cycle == v.xtr, "R9", $sformatf("extra pb=%0h", v.pb), extra_cycle, v.xtr);
        chk(wb_en == v.wb, "R2", $sformatf("wb_en pb=%0h", v.pb), wb_en, v.wb);
        if (v.wb) begin
            chk(wb_sel == v.wsel, "R2", $sformatf("wb_sel pb=%0h", v.pb), wb_sel, v.wsel);
            chk(wb_data == v.wdat, "R2", $sformatf("wb_data pb=%0h", v.pb), wb_data, v.wdat);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done single cycle", done, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // r10_ reset state
        chk(done == 1'b0, "R10", "reset done", done, 0);
        chk(ext_req == 1'b0 && mem_req == 1'b0, "R10", "reset req",
            {ext_req, mem_req}, 0);
        chk(wb_en == 1'b0 && illegal == 1'b0, "R10", "reset flags",
            {wb_en, illegal}, 0);

        for (int i = 0; i < NV; i++) run_vec(TBL[i], 0);

        // R6 with wait states on the read port
        run_vec(TBL[16], 3);
        run_vec(TBL[17], 2);

        // R10 latency: no fetch form finishes on the second edge
        @(negedge clk);
        postbyte = 8'h05;
        restrict_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R10", "done one edge after start", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R10", "done two edges after start", done, 1);
        chk(ea == 16'h1005, "R1", "latency run ea", ea, 16'h1005);
        @(negedge clk);

        // R3 with a different X value: post keeps original, pre uses update
        reg_x = 16'hFFFE;
        run_vec('{4'd3, 8'h37, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'hFFFE, 1'b1, 2'd0, 16'h0006,
                  1'b0, 1'b0}, 0);
        run_vec('{4'd3, 8'h27, 1'b0, 8'h00, 8'h00, 2'd0, 2'd0, 16'h0006, 1'b1, 2'd0, 16'h0006,
                  1'b0, 1'b0}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule